// File: doc/BRIEF.md
# Video-CPU Bus Sharing Arbiter

This block decides, phase by phase, who drives a memory bus shared by a video fetch engine and a CPU. Each bus cycle has two halves, signalled by the `phase2` input (low for the first half, high for the second). In quiet operation the video engine owns the first half and the CPU the second. The CPU is told that the bus is usable by a high `bus_avail`, and the address-enable output `addr_en` is high whenever the CPU side owns the lines.

Some video fetches also need the second half of a bus cycle. Two kinds exist: character-pointer fetches and sprite data fetches. The video engine announces each such steal ahead of time on a small schedule stream (`plan_valid`/`plan_ready`/`plan_kind`). The CPU can only be halted on reads and never writes more than three times in a row. So the arbiter drops `bus_avail` a fixed lead of `LEAD` (default 3) whole bus cycles before the stolen half-cycle. In the stolen half it keeps `addr_en` low, enables the video drivers and pulses `steal_strobe` with the fetch kind.

The schedule stream is accepted only at the end of a bus cycle: `plan_ready` equals `phase2`. A beat transfers on the clock edge where `plan_valid` and `plan_ready` are both high. A producer that raises `plan_valid` in the first half must hold it, and `plan_kind`, until the second half ends. If it drops `plan_valid` before then, the offer is withdrawn with no effect. The stream never stalls in the second half: every offer made then is taken.

Top module: `vidcpu_bus_arbiter`

## Requirements
- R1: Right after reset, `bus_avail` is 1, `steal_strobe` is 0 and `addr_en` follows `phase2`, with no steal pending.
- R2: With no steal pending, `addr_en` is 0 and `vid_drive_en` is 1 while `phase2` is 0. `addr_en` is 1 and `vid_drive_en` is 0 while `phase2` is 1. `bus_avail` stays 1.
- R3: A plan beat accepted at the end of bus cycle k holds `bus_avail` at 0 from bus cycle k+1 through bus cycle k+1+LEAD. The stolen access falls in the second half of bus cycle k+1+LEAD. Every stolen access therefore follows at least LEAD whole bus cycles of `bus_avail` low.
- R4: In a stolen second half, `addr_en` is 0, `vid_drive_en` is 1 and `steal_strobe` is 1. `steal_kind` repeats the accepted `plan_kind`: 0 is a character-pointer fetch and 1 is a sprite fetch.
- R5: `bus_avail` returns to 1 in the bus cycle after the last stolen access, unless another steal is due within the next LEAD+1 bus cycles.
- R6: Steals whose low windows touch or overlap give one unbroken low period of `bus_avail`, with no high cycle between them.
- R7: `plan_ready` equals `phase2`. A `plan_valid` that is withdrawn before the second half causes no steal and leaves `bus_avail` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock, one edge per bus phase |
| rst_n | input | 1 | Active-low synchronous reset |
| phase2 | input | 1 | 0 in the first half of a bus cycle, 1 in the second; alternates |
| plan_valid | input | 1 | Schedule beat offered: steal the second half LEAD+1 bus cycles later |
| plan_kind | input | 1 | Fetch kind of the offered steal (0 character pointer, 1 sprite) |
| plan_ready | output | 1 | Schedule beat accepted at this edge when high (equals `phase2`) |
| bus_avail | output | 1 | High when the CPU may use its second half |
| addr_en | output | 1 | High when the CPU side owns address and data lines |
| vid_drive_en | output | 1 | Video address/data drivers enabled; low means tri-stated |
| steal_strobe | output | 1 | High during a stolen second half |
| steal_kind | output | 1 | Kind of the current stolen fetch |

## Verification
The bench goes after the lead count. A pipeline one stage short or long would put the steal a bus cycle early or late and leave the CPU fewer or more than LEAD warning cycles. That shows as a strobe in the wrong half-cycle or a `bus_avail` edge off by one. Steals planned on consecutive cycles and with a one-cycle gap test merging: a design that rebuilt the flag from the head stage alone would let `bus_avail` blip high between them. Steals five cycles apart must show `bus_avail` recovering, which a design that latched the low state would miss. Early-only offers and sprite versus character kinds catch a ready that accepts in the wrong half and a kind bit lost in the pipeline.

// File: rtl/vcb_pkg.sv
package vcb_pkg;

  typedef enum logic {
    FETCH_CHARPTR = 1'b0,
    FETCH_SPRITE  = 1'b1
  } fetch_kind_e;

  typedef struct packed {
    logic        vld;
    fetch_kind_e kind;
  } steal_slot_t;

endpackage

// File: rtl/vcb_lead_pipe.sv
// Countdown pipeline of planned steals: one slot per bus cycle of lead.
module vcb_lead_pipe
  import vcb_pkg::*;
#(
  parameter int LEAD = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        shift_en,
  input  logic        push_vld,
  input  fetch_kind_e push_kind,
  output logic        any_pend,
  output logic        head_vld,
  output fetch_kind_e head_kind
);

  localparam int DEPTH = LEAD + 1;

  steal_slot_t [DEPTH-1:0] slot_q;
  logic        [DEPTH-1:0] vld_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (shift_en) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        slot_q[i] <= slot_q[i+1];
      end
      slot_q[DEPTH-1] <= '{vld: push_vld, kind: push_kind};
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_vld
      assign vld_vec[g] = slot_q[g].vld;
    end
  endgenerate

  assign any_pend  = |vld_vec;
  assign head_vld  = slot_q[0].vld;
  assign head_kind = slot_q[0].kind;

endmodule

// File: rtl/vcb_phase_gate.sv
// Decides ownership of the lines within the current half-cycle.
module vcb_phase_gate (
  input  logic phase2,
  input  logic steal_now,
  output logic addr_en,
  output logic vid_drive_en,
  output logic steal_strobe
);

  always_comb begin
    steal_strobe = phase2 & steal_now;
    addr_en      = phase2 & ~steal_now;
    vid_drive_en = ~addr_en;
  end

endmodule

// File: rtl/vidcpu_bus_arbiter.sv
module vidcpu_bus_arbiter
  import vcb_pkg::*;
#(
  parameter int LEAD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase2,
  input  logic plan_valid,
  input  logic plan_kind,
  output logic plan_ready,
  output logic bus_avail,
  output logic addr_en,
  output logic vid_drive_en,
  output logic steal_strobe,
  output logic steal_kind
);

  localparam int CW = $clog2(LEAD + 2);
  localparam logic [CW-1:0] CNT_MAX = CW'(LEAD + 1);

  logic        accept;
  logic        any_pend;
  logic        head_vld;
  fetch_kind_e head_kind;

  // The stream is taken only on the edge that closes a bus cycle.
  assign plan_ready = phase2;
  assign accept     = plan_valid & plan_ready;

  vcb_lead_pipe #(.LEAD(LEAD)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (phase2),
    .push_vld (accept),
    .push_kind(fetch_kind_e'(plan_kind)),
    .any_pend (any_pend),
    .head_vld (head_vld),
    .head_kind(head_kind)
  );

  vcb_phase_gate u_gate (
    .phase2      (phase2),
    .steal_now   (head_vld),
    .addr_en     (addr_en),
    .vid_drive_en(vid_drive_en),
    .steal_strobe(steal_strobe)
  );

  assign bus_avail  = ~any_pend;
  assign steal_kind = head_kind;

  // Checker-only count of whole bus cycles spent with bus_avail low.
  logic [CW-1:0] low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (phase2) begin
      if (bus_avail)              low_cnt <= '0;
      else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
    end
  end

  AST_ACCEPT_DROPS_BA: assert property (@(posedge clk) disable iff (!rst_n)
    (plan_valid && plan_ready) |=> !bus_avail); // R3
  AST_LEAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    steal_strobe |-> (low_cnt >= CW'(LEAD))); // R3
  AST_STEAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    steal_strobe |-> (!bus_avail && !addr_en && vid_drive_en)); // R4
  AST_NO_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase2 && !bus_avail && !steal_strobe) |=> !bus_avail); // R6

endmodule

// File: tb/vidcpu_bus_arbiter_tb.sv
module vidcpu_bus_arbiter_tb;

  localparam int LEAD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase2 = 1'b0;
  logic plan_valid = 1'b0;
  logic plan_kind = 1'b0;
  logic plan_ready, bus_avail, addr_en, vid_drive_en, steal_strobe, steal_kind;

  always #10 clk = ~clk;

  vidcpu_bus_arbiter #(.LEAD(LEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .phase2(phase2),
    .plan_valid(plan_valid), .plan_kind(plan_kind), .plan_ready(plan_ready),
    .bus_avail(bus_avail), .addr_en(addr_en), .vid_drive_en(vid_drive_en),
    .steal_strobe(steal_strobe), .steal_kind(steal_kind)
  );

  typedef struct {
    logic  ph2, ba, aen, drv, stb, kind;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   sched [0:511];
  bit   kind_at [0:511];
  int   bidx = 0;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per half-cycle, away from the clock edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "bus_avail", bus_avail, e.ba);
      chk(e.tag, "addr_en", addr_en, e.aen);
      chk(e.tag, "vid_drive_en", vid_drive_en, e.drv);
      chk(e.tag, "steal_strobe", steal_strobe, e.stb);
      chk(e.tag, "plan_ready", plan_ready, e.ph2);
      if (e.stb) chk(e.tag, "steal_kind", steal_kind, e.kind);
    end
  end

  // Driver: one bus cycle; pushes expectations from the requirement timing.
  task automatic bus(input bit req, input bit kind, input bit early, input string tag);
    bit pend = 1'b0;
    bit stl;
    exp_t e;
    for (int i = 0; i <= LEAD; i++) pend |= sched[bidx + i];
    stl = sched[bidx];
    @(posedge clk); #1;
    phase2 = 1'b0; plan_valid = req | early; plan_kind = kind;
    e = '{ph2: 1'b0, ba: ~pend, aen: 1'b0, drv: 1'b1, stb: 1'b0, kind: 1'b0, tag: tag};
    q.push_back(e);
    @(posedge clk); #1;
    phase2 = 1'b1; plan_valid = req;
    e = '{ph2: 1'b1, ba: ~pend, aen: ~stl, drv: stl, stb: stl, kind: kind_at[bidx], tag: tag};
    q.push_back(e);
    if (req) begin
      sched[bidx + 1 + LEAD]   = 1'b1;
      kind_at[bidx + 1 + LEAD] = kind;
    end
    bidx++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) bus(1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    fork
      begin
        for (int i = 0; i < 6; i++) begin
          @(posedge clk); #1; phase2 = ~phase2;
        end
        @(posedge clk); #1; rst_n = 1'b1; phase2 = 1'b1;
        idle(2, "R1");
        idle(3, "R2");
        bus(1'b1, 1'b0, 1'b0, "R3");        // character-pointer steal
        idle(5, "R3");
        idle(2, "R5");
        bus(1'b1, 1'b1, 1'b0, "R4");        // sprite steal
        idle(6, "R4");
        bus(1'b1, 1'b1, 1'b0, "R6");        // three in a row
        bus(1'b1, 1'b0, 1'b0, "R6");
        bus(1'b1, 1'b1, 1'b0, "R6");
        bus(1'b0, 1'b0, 1'b0, "R6");
        bus(1'b1, 1'b0, 1'b0, "R6");        // one-cycle gap still merges
        idle(7, "R6");
        bus(1'b1, 1'b0, 1'b0, "R5");        // spaced: bus_avail recovers between
        idle(4, "R5");
        bus(1'b1, 1'b1, 1'b0, "R5");
        idle(6, "R5");
        bus(1'b0, 1'b1, 1'b1, "R7");        // offer withdrawn before phase two
        idle(6, "R7");
        @(posedge clk); @(posedge clk); @(posedge clk);
      end
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule